// File: doc/BRIEF.md
# Boot Remap Address Decoder

This block sits on the address path of a 32-bit processor and turns each bus address into a select for one target region. It also produces an offset with the region base removed, and it shapes the read data coming back from the selected target. The top four address bits pick the region. The low window at tag 0x0 holds the reset and exception vectors at address zero. That window is served either by the serial boot flash or by main DRAM, never by both.

After power-on the low window belongs to the flash, and DRAM cannot be reached from the processor at all. Moving the window to DRAM takes two steps. First, software writes a one into bit 0 of a control word on the 16-bit register bus. Second, the processor is reset. The mapping changes on that reset and not before, so the code that arms the remap keeps running from flash until the reset pulse. A processor reset leaves the armed state alone. Only power-on reset brings the low window back to flash.

The register bus carries 16-bit registers, one per 32-bit address slot, so its offset is a word index and only the low half of its data is meaningful. The local UART has one register per byte address.

Top module: `bootRemapDecoder`

## Requirements
- R1: For a valid access, at most one bit of `regionSel` is set. Bit positions are 0 flash, 1 DRAM, 2 UART, 3 register bus, 4 SRAM A, 5 SRAM B. Tags are taken from address bits [31:28]: 0x9 selects UART, 0xA the register bus, 0xB SRAM A, 0xC SRAM B, and 0x0 the low window.
- R2: After power-on reset, an access with tag 0x0 selects the flash (bit 0).
- R3: While the remap is not active, the DRAM select (bit 1) is never asserted.
- R4: A valid write to address 0xA000_0000 + 4*CTRL_WORD_IDX with `busWdataLsb`=1 arms the remap. The low window does not change until a processor reset follows.
- R5: When `cpuRstN` is low on a clock edge while the remap is armed, tag 0x0 selects DRAM (bit 1) from the next cycle on. A processor reset without arming leaves the flash selected.
- R6: The armed and active states survive processor resets, and a control write with `busWdataLsb`=0 does not disarm. Only `porRstN` returns the low window to flash.
- R7: A valid access to any other tag raises `busErr` for that cycle, with no select and `busRdata` equal to zero.
- R8: `busOffset` carries address bits [27:0] for the low window and both SRAM regions, bits [2:0] for the UART, and the word index (bits [27:2]) for the register bus.
- R9: `busRdata` passes `tgtRdata` unchanged for the low window and the SRAMs, keeps only bits [15:0] for the register bus and only bits [7:0] for the UART, with the upper bits zero.
- R10: With `busValid` low, no select and no error are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, synchronous |
| cpuRstN | input | 1 | Processor reset, active low, synchronous |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | Access is a write |
| busAddr | input | 32 | Byte address |
| busWdataLsb | input | 1 | Bit 0 of write data (control arm bit) |
| tgtRdata | input | 32 | Read data returned by the selected target |
| regionSel | output | 6 | One-hot region select |
| busErr | output | 1 | Unmapped access |
| busOffset | output | 28 | Address with region base removed |
| busRdata | output | 32 | Shaped read data to the processor |

## Verification
The bench writes the control word and then keeps probing the low window before any reset. A design that applied the remap at once would jump to DRAM while code is still running from flash. It resets the processor both unarmed and armed, and it writes a zero to the control word after arming. A design that cleared state on the processor reset, or that let a zero disarm, would fall back to flash. A power-on reset must restore flash. Random unmapped tags and register-bus or UART accesses with full-width target data would expose a design that leaks a select, returns data on an error, or fails to trim the offset or data.

// File: rtl/bootRemapPkg.sv
package bootRemapPkg;
  localparam int NUM_RGN = 6;
  localparam int RGN_FLASH = 0;
  localparam int RGN_DRAM  = 1;
  localparam int RGN_UART  = 2;
  localparam int RGN_REG   = 3;
  localparam int RGN_SRAMA = 4;
  localparam int RGN_SRAMB = 5;

  localparam logic [3:0] TAG_LOW   = 4'h0;
  localparam logic [3:0] TAG_UART  = 4'h9;
  localparam logic [3:0] TAG_REG   = 4'hA;
  localparam logic [3:0] TAG_SRAMA = 4'hB;
  localparam logic [3:0] TAG_SRAMB = 4'hC;

  typedef struct packed {
    logic lowToDram;
    logic armed;
  } remapStrobes_t;
endpackage

// File: rtl/remapControl.sv
module remapControl
  import bootRemapPkg::*;
(
  input  logic          clk,
  input  logic          porRstN,
  input  logic          cpuRstN,
  input  logic          armReq,
  output remapStrobes_t strobes
);
  logic armedQ;
  logic activeQ;

  always_ff @(posedge clk) begin
    if (!porRstN) begin
      armedQ <= 1'b0;
    end else if (armReq) begin
      armedQ <= 1'b1;
    end
  end

  // the active mapping only moves on a processor reset edge
  always_ff @(posedge clk) begin
    if (!porRstN) begin
      activeQ <= 1'b0;
    end else if (!cpuRstN) begin
      activeQ <= armedQ;
    end
  end

  always_comb begin
    strobes.armed     = armedQ;
    strobes.lowToDram = activeQ;
  end

  // R5: mapping changes only right after a processor reset cycle
  assert_remap_on_cpu_reset_R5: assert property (@(posedge clk) disable iff (!porRstN)
    !$stable(activeQ) |-> $past(!cpuRstN));

  // R6: once armed, only power-on reset clears it
  assert_armed_sticky_R6: assert property (@(posedge clk) disable iff (!porRstN)
    $past(armedQ) |-> armedQ);

  // R4: arming needs a control write
  assert_arm_needs_write_R4: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(armedQ) |-> $past(armReq));
endmodule

// File: rtl/remapDatapath.sv
module remapDatapath
  import bootRemapPkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 32,
  parameter int REG_DATA_W    = 16,
  parameter int UART_IDX_W    = 3,
  parameter int UART_DATA_W   = 8,
  parameter int CTRL_WORD_IDX = 64,
  localparam int TAG_W        = 4,
  localparam int OFF_W        = ADDR_W - TAG_W
) (
  input  logic                clk,
  input  logic                porRstN,
  input  remapStrobes_t       strobes,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWdataLsb,
  input  logic [DATA_W-1:0]   tgtRdata,
  output logic [NUM_RGN-1:0]  regionSel,
  output logic                busErr,
  output logic [OFF_W-1:0]    busOffset,
  output logic [DATA_W-1:0]   busRdata,
  output logic                armReq
);
  localparam int WIDX_W = OFF_W - 2;

  logic [TAG_W-1:0]  addrTag;
  logic [WIDX_W-1:0] wordIdx;
  logic [NUM_RGN-1:0] rawSel;

  assign addrTag = busAddr[ADDR_W-1 -: TAG_W];
  assign wordIdx = busAddr[OFF_W-1:2];

  always_comb begin
    rawSel = '0;
    unique case (addrTag)
      TAG_LOW: begin
        if (strobes.lowToDram) rawSel[RGN_DRAM] = 1'b1;
        else                   rawSel[RGN_FLASH] = 1'b1;
      end
      TAG_UART:  rawSel[RGN_UART]  = 1'b1;
      TAG_REG:   rawSel[RGN_REG]   = 1'b1;
      TAG_SRAMA: rawSel[RGN_SRAMA] = 1'b1;
      TAG_SRAMB: rawSel[RGN_SRAMB] = 1'b1;
      default:   rawSel = '0;
    endcase
  end

  assign regionSel = busValid ? rawSel : '0;
  assign busErr    = busValid && (rawSel == '0);

  always_comb begin
    busOffset = busAddr[OFF_W-1:0];
    if (rawSel[RGN_UART]) busOffset = OFF_W'(busAddr[UART_IDX_W-1:0]);
    else if (rawSel[RGN_REG]) busOffset = OFF_W'(wordIdx);
  end

  always_comb begin
    busRdata = tgtRdata;
    if (rawSel == '0)          busRdata = '0;
    else if (rawSel[RGN_REG])  busRdata = DATA_W'(tgtRdata[REG_DATA_W-1:0]);
    else if (rawSel[RGN_UART]) busRdata = DATA_W'(tgtRdata[UART_DATA_W-1:0]);
  end

  assign armReq = busValid && busWrite && rawSel[RGN_REG] &&
                  (wordIdx == WIDX_W'(CTRL_WORD_IDX)) && busWdataLsb;

  // R1: never more than one target selected
  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!porRstN)
    $onehot0(regionSel));

  // R3: DRAM hidden while flash owns the low window
  assert_dram_hidden_R3: assert property (@(posedge clk) disable iff (!porRstN)
    !strobes.lowToDram |-> !regionSel[RGN_DRAM]);

  // R7: error carries no select and no data
  assert_err_clean_R7: assert property (@(posedge clk) disable iff (!porRstN)
    busErr |-> (regionSel == '0) && (busRdata == '0));

  // R10: idle bus is quiet
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!porRstN)
    !busValid |-> (regionSel == '0) && !busErr);
endmodule

// File: rtl/bootRemapDecoder.sv
module bootRemapDecoder
  import bootRemapPkg::*;
#(
  parameter int CTRL_WORD_IDX = 64
) (
  input  logic        clk,
  input  logic        porRstN,
  input  logic        cpuRstN,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [31:0] busAddr,
  input  logic        busWdataLsb,
  input  logic [31:0] tgtRdata,
  output logic [5:0]  regionSel,
  output logic        busErr,
  output logic [27:0] busOffset,
  output logic [31:0] busRdata
);
  remapStrobes_t strobes;
  logic armReq;

  remapControl u_ctrl (
    .clk     (clk),
    .porRstN (porRstN),
    .cpuRstN (cpuRstN),
    .armReq  (armReq),
    .strobes (strobes)
  );

  remapDatapath #(
    .ADDR_W        (32),
    .DATA_W        (32),
    .CTRL_WORD_IDX (CTRL_WORD_IDX)
  ) u_path (
    .clk         (clk),
    .porRstN     (porRstN),
    .strobes     (strobes),
    .busValid    (busValid),
    .busWrite    (busWrite),
    .busAddr     (busAddr),
    .busWdataLsb (busWdataLsb),
    .tgtRdata    (tgtRdata),
    .regionSel   (regionSel),
    .busErr      (busErr),
    .busOffset   (busOffset),
    .busRdata    (busRdata),
    .armReq      (armReq)
  );
endmodule

// File: tb/test_bootRemapDecoder.sv
module test_bootRemapDecoder;
  localparam int CTRL_IDX = 64;
  localparam logic [31:0] CTRL_ADDR = 32'hA000_0000 | (CTRL_IDX << 2);

  logic clk = 1'b0;
  logic porRstN = 1'b0;
  logic cpuRstN = 1'b1;
  logic busValid = 1'b0;
  logic busWrite = 1'b0;
  logic [31:0] busAddr = '0;
  logic busWdataLsb = 1'b0;
  logic [31:0] tgtRdata = '0;
  logic [5:0] regionSel;
  logic busErr;
  logic [27:0] busOffset;
  logic [31:0] busRdata;

  int checks = 0;
  int failures = 0;
  bit modelArmed = 0;
  bit modelActive = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bootRemapDecoder #(.CTRL_WORD_IDX(CTRL_IDX)) i_bootRemapDecoder (
    .clk(clk), .porRstN(porRstN), .cpuRstN(cpuRstN), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdataLsb(busWdataLsb),
    .tgtRdata(tgtRdata), .regionSel(regionSel), .busErr(busErr),
    .busOffset(busOffset), .busRdata(busRdata)
  );

  function automatic logic [5:0] expSel(logic v, logic [31:0] a, bit act);
    logic [5:0] s = '0;
    case (a[31:28])
      4'h0: s = act ? 6'b000010 : 6'b000001;
      4'h9: s = 6'b000100;
      4'hA: s = 6'b001000;
      4'hB: s = 6'b010000;
      4'hC: s = 6'b100000;
      default: s = '0;
    endcase
    return v ? s : '0;
  endfunction

  function automatic logic [27:0] expOff(logic [31:0] a);
    if (a[31:28] == 4'h9) return {25'd0, a[2:0]};
    if (a[31:28] == 4'hA) return {2'd0, a[27:2]};
    return a[27:0];
  endfunction

  function automatic logic [31:0] expData(logic [31:0] a, logic [31:0] d);
    case (a[31:28])
      4'h0, 4'hB, 4'hC: return d;
      4'h9: return {24'd0, d[7:0]};
      4'hA: return {16'd0, d[15:0]};
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, sample 1 ns later, then let the edge pass
  task automatic access(string req, logic v, logic w, logic [31:0] a, logic lsb,
                        logic [31:0] d);
    logic [5:0] s;
    @(negedge clk);
    busValid = v; busWrite = w; busAddr = a; busWdataLsb = lsb; tgtRdata = d;
    #1;
    s = expSel(v, a, modelActive);
    check({req, " sel"}, 64'(regionSel), 64'(s));
    check({req, " err"}, 64'(busErr), 64'(v && s == 0));
    if (v && s != 0) begin
      check({req, " off"}, 64'(busOffset), 64'(expOff(a)));
      check({req, " rdata"}, 64'(busRdata), 64'(expData(a, d)));
    end
    if (v && s == 0) check({req, " errdata"}, 64'(busRdata), 64'd0);
    @(posedge clk);
    if (v && w && lsb && a[31:28] == 4'hA && a[27:2] == 26'(CTRL_IDX)) modelArmed = 1;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic cpuReset();
    @(negedge clk);
    cpuRstN = 0;
    @(posedge clk);
    modelActive = modelArmed;
    @(negedge clk);
    cpuRstN = 1;
  endtask

  task automatic porReset();
    @(negedge clk);
    porRstN = 0;
    repeat (2) @(posedge clk);
    modelArmed = 0; modelActive = 0;
    @(negedge clk);
    porRstN = 1;
  endtask

  task automatic randomBurst(int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a = $urandom;
      int pick = $urandom_range(0, 6);
      case (pick)
        0: a[31:28] = 4'h0;
        1: a[31:28] = 4'h9;
        2: a[31:28] = 4'hA;
        3: a[31:28] = 4'hB;
        4: a[31:28] = 4'hC;
        default: ;
      endcase
      access("R1 R7 R8 R9 random", logic'($urandom_range(0, 7) != 0),
             logic'($urandom_range(0, 1)), a, 1'b0, $urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    porRstN = 1;
    #1;
    check("R10 reset idle sel", 64'(regionSel), 0);
    check("R10 reset idle err", 64'(busErr), 0);
    access("R2 flash after POR", 1, 0, 32'h0000_0000, 0, 32'hDEAD_BEEF);
    access("R10 idle", 0, 0, 32'h0000_0010, 0, 32'h1);
    access("R7 unmapped 0xF", 1, 0, 32'hF000_1234, 0, 32'hFFFF_FFFF);
    access("R7 unmapped 0x1", 1, 1, 32'h1000_0000, 1, 32'h5);
    access("R9 uart byte", 1, 0, 32'h9000_0007, 0, 32'hAABB_CCDD);
    access("R8 reg word idx", 1, 0, 32'hA123_4566, 0, 32'h1234_5678);
    access("R8 sram A", 1, 0, 32'hBFFF_FFFF, 0, 32'h0F0F_0F0F);
    randomBurst(200);
    cpuReset();
    access("R5 unarmed cpu reset keeps flash", 1, 0, 32'h0000_0100, 0, 32'h1);
    access("R4 arm write zero no effect", 1, 1, CTRL_ADDR, 0, 32'h0);
    access("R4 arm write", 1, 1, CTRL_ADDR, 1, 32'h0);
    access("R4 still flash before reset", 1, 0, 32'h0000_0004, 0, 32'h2);
    access("R3 dram hidden while armed", 1, 0, 32'h0FFF_FFFC, 0, 32'h3);
    cpuReset();
    access("R5 dram after reset", 1, 0, 32'h0000_0000, 0, 32'h4);
    check("R5 model active", 64'(modelActive), 1);
    access("R6 zero write no disarm", 1, 1, CTRL_ADDR, 0, 32'h0);
    cpuReset();
    access("R6 dram survives cpu reset", 1, 0, 32'h0000_0008, 0, 32'h5);
    randomBurst(200);
    porReset();
    access("R6 POR restores flash", 1, 0, 32'h0000_0000, 0, 32'h6);
    cpuReset();
    access("R6 POR cleared arm", 1, 0, 32'h0000_0000, 0, 32'h7);
    randomBurst(100);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule